// File: doc/BRIEF.md
# Packed Word Dot-Product Accumulator

This block is a SIMD execution slice for a vector datapath. Every 32-bit result lane combines one 32-bit accumulator lane with two adjacent 16-bit words from operand A and the two matching words from operand B. It forms the two word products, adds both to the accumulator, and writes the packed lane results into a registered output one clock after the request.

A two-bit mode input selects how the operands are interpreted. A can be signed while B is unsigned, A can be unsigned while B is signed, or both can be unsigned. In the two mixed modes the accumulator and the result are signed 32-bit values. In the all-unsigned mode they are unsigned. A separate enable picks how the three-term sum is reduced to 32 bits: it either wraps, or it clamps to the signed or unsigned limits that match the mode. The lane count is a parameter, 4 for a 128-bit datapath or 8 for a 256-bit one. The output port is always the full 256-bit width, and any bits above the active lanes read as zero.

Top module: `wdp_accum_unit`

## Requirements
- R1: Lane j occupies bits [32j+31:32j] of `acc_in` and `result`, and word k occupies bits [16k+15:16k] of `a_in` and `b_in`. Result lane j equals acc lane j + A[2j]*B[2j] + A[2j+1]*B[2j+1], and each lane is independent of the other lanes.
- R2: With `mode` = 2'b00, A words are sign-extended and B words are zero-extended, and the accumulator is a signed value.
- R3: With `mode` = 2'b01, A words are zero-extended and B words are sign-extended, and the accumulator is a signed value.
- R4: With `mode` = 2'b10, both A and B words and the accumulator are unsigned. Code 2'b11 behaves the same as 2'b10.
- R5: With `sat_en` = 0, each lane result is the exact sum modulo 2^32.
- R6: With `sat_en` = 1 in mode 2'b00 or 2'b01, a sum above 0x7FFFFFFF gives 0x7FFFFFFF and a sum below -2^31 gives 0x80000000.
- R7: With `sat_en` = 1 in mode 2'b10 or 2'b11, a sum above 2^32-1 gives 0xFFFFFFFF, so the result is never below the accumulator lane.
- R8: `result` bits at and above LANES*32 are always zero.
- R9: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and the new result appears in that same cycle. While `in_valid` is low, `result` holds its value.
- R10: A synchronous reset (`rst` high at a clock edge) clears `result` to zero and drops `out_valid`.
- R11: Saturation decides on the exact full-precision sum, with no product or partial sum truncated. For example, a large positive product that is cancelled by a large negative product yields the exact result and does not clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present this cycle |
| mode | input | 2 | Signedness selection (00 A signed/B unsigned, 01 A unsigned/B signed, 1x both unsigned) |
| sat_en | input | 1 | 1 = clamp the sum, 0 = wrap the sum |
| acc_in | input | LANES*32 | Packed 32-bit accumulator lanes |
| a_in | input | LANES*32 | Packed 16-bit A words |
| b_in | input | LANES*32 | Packed 16-bit B words |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 256 | Packed 32-bit result lanes, zero above LANES*32 |

## Verification
The only state is the output register, so any internal fault shows up on `result` or `out_valid` in the cycle right after the request. Such faults include a wrong extension choice, a product cut to 32 bits, a misplaced clamp limit, or a register that fails to hold. The corner words 0x8000, 0x7FFF and 0xFFFF, combined with accumulators at the signed and unsigned extremes, separate every extension and clamp error from the correct answer. Lanes receive different operand rotations, so a lane-indexing fault shows up as a mismatch in a single lane.

// File: rtl/wdp_pkg.sv
package wdp_pkg;

    localparam int WORD_W_DEF = 16;
    localparam int LANE_W_DEF = 32;
    localparam int PAIRS_DEF  = 2;

    typedef enum logic [1:0] {
        MODE_SU  = 2'b00,
        MODE_US  = 2'b01,
        MODE_UU  = 2'b10,
        MODE_UU2 = 2'b11
    } wdp_mode_e;

    function automatic logic mode_a_signed(wdp_mode_e m);
        return (m == MODE_SU);
    endfunction

    function automatic logic mode_b_signed(wdp_mode_e m);
        return (m == MODE_US);
    endfunction

    // mixed modes treat accumulator and result as signed
    function automatic logic mode_res_signed(wdp_mode_e m);
        return !m[1];
    endfunction

endpackage

// File: rtl/wdp_word_mult.sv
module wdp_word_mult #(
    parameter int WORD_W = 16,
    localparam int EXT_W  = WORD_W + 1,
    localparam int PROD_W = 2 * EXT_W
) (
    input  logic [WORD_W-1:0]        a_word,
    input  logic [WORD_W-1:0]        b_word,
    input  logic                     a_sgn,
    input  logic                     b_sgn,
    output logic signed [PROD_W-1:0] prod
);
    logic signed [EXT_W-1:0] a_x;
    logic signed [EXT_W-1:0] b_x;

    // one guard bit makes both extensions fit a signed multiplier
    always_comb begin
        a_x  = $signed({a_sgn & a_word[WORD_W-1], a_word});
        b_x  = $signed({b_sgn & b_word[WORD_W-1], b_word});
        prod = a_x * b_x;
    end

endmodule

// File: rtl/wdp_lane.sv
module wdp_lane #(
    parameter int WORD_W = 16,
    parameter int LANE_W = 32,
    parameter int PAIRS  = 2,
    localparam int PROD_W = 2 * (WORD_W + 1),
    localparam int BASE_W = (PROD_W > LANE_W + 1) ? PROD_W : LANE_W + 1,
    localparam int SUM_W  = BASE_W + $clog2(PAIRS + 1)
) (
    input  logic [LANE_W-1:0]       acc,
    input  logic [PAIRS*WORD_W-1:0] a_pair,
    input  logic [PAIRS*WORD_W-1:0] b_pair,
    input  logic                    a_sgn,
    input  logic                    b_sgn,
    input  logic                    res_sgn,
    input  logic                    sat_en,
    output logic [LANE_W-1:0]       res
);
    localparam logic signed [SUM_W-1:0] S_MAX =
        {{(SUM_W-LANE_W+1){1'b0}}, {(LANE_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] S_MIN =
        {{(SUM_W-LANE_W+1){1'b1}}, {(LANE_W-1){1'b0}}};
    localparam logic signed [SUM_W-1:0] U_MAX =
        {{(SUM_W-LANE_W){1'b0}}, {LANE_W{1'b1}}};

    logic signed [PROD_W-1:0] prod [PAIRS];
    logic signed [SUM_W-1:0]  acc_x;
    logic signed [SUM_W-1:0]  sum;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        wdp_word_mult #(.WORD_W(WORD_W)) u_mult (
            .a_word (a_pair[p*WORD_W +: WORD_W]),
            .b_word (b_pair[p*WORD_W +: WORD_W]),
            .a_sgn  (a_sgn),
            .b_sgn  (b_sgn),
            .prod   (prod[p])
        );
    end

    // full-precision sum: no operand is narrowed before the clamp decision
    always_comb begin
        acc_x = $signed({{(SUM_W-LANE_W){res_sgn & acc[LANE_W-1]}}, acc});
        sum   = acc_x;
        for (int p = 0; p < PAIRS; p++) begin
            sum = sum + $signed({{(SUM_W-PROD_W){prod[p][PROD_W-1]}}, prod[p]});
        end
    end

    always_comb begin
        res = sum[LANE_W-1:0];
        if (sat_en) begin
            if (res_sgn) begin
                if (sum > S_MAX)      res = S_MAX[LANE_W-1:0];
                else if (sum < S_MIN) res = S_MIN[LANE_W-1:0];
            end else begin
                if (sum > U_MAX)      res = U_MAX[LANE_W-1:0];
                else if (sum < 0)     res = '0;
            end
        end
    end

endmodule

// File: rtl/wdp_accum_unit.sv
module wdp_accum_unit
    import wdp_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int WORD_W = WORD_W_DEF,
    parameter int LANE_W = LANE_W_DEF,
    parameter int MAX_W  = 256,
    localparam int PAIRS  = PAIRS_DEF,
    localparam int ACT_W  = LANES * LANE_W,
    localparam int OPND_W = LANES * PAIRS * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic              sat_en,
    input  logic [ACT_W-1:0]  acc_in,
    input  logic [OPND_W-1:0] a_in,
    input  logic [OPND_W-1:0] b_in,
    output logic              out_valid,
    output logic [MAX_W-1:0]  result
);
    typedef struct packed {
        logic             vld;
        logic [MAX_W-1:0] res;
    } stage_t;

    wdp_mode_e        mode_e;
    logic             a_sgn;
    logic             b_sgn;
    logic             r_sgn;
    logic [ACT_W-1:0] lane_res;
    stage_t           stage_d;
    stage_t           stage_q;

    always_comb begin
        mode_e = wdp_mode_e'(mode);
        a_sgn  = mode_a_signed(mode_e);
        b_sgn  = mode_b_signed(mode_e);
        r_sgn  = mode_res_signed(mode_e);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        wdp_lane #(
            .WORD_W (WORD_W),
            .LANE_W (LANE_W),
            .PAIRS  (PAIRS)
        ) u_lane (
            .acc     (acc_in[g*LANE_W +: LANE_W]),
            .a_pair  (a_in[g*PAIRS*WORD_W +: PAIRS*WORD_W]),
            .b_pair  (b_in[g*PAIRS*WORD_W +: PAIRS*WORD_W]),
            .a_sgn   (a_sgn),
            .b_sgn   (b_sgn),
            .res_sgn (r_sgn),
            .sat_en  (sat_en),
            .res     (lane_res[g*LANE_W +: LANE_W])
        );

        // unsigned clamp never lands below the accumulator lane
        assert_uu_no_drop_R7: assert property (@(posedge clk) disable iff (rst)
            (in_valid && sat_en && mode[1])
            |=> (result[g*LANE_W +: LANE_W] >= $past(acc_in[g*LANE_W +: LANE_W])));
    end

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.res             = '0;
            stage_d.res[ACT_W-1:0]  = lane_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= '0;
        else     stage_q <= stage_d;
    end

    assign out_valid = stage_q.vld;
    assign result    = stage_q.res;

    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_result_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    assert_zero_words_pass_acc_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && a_in == '0 && b_in == '0)
        |=> (result[ACT_W-1:0] == $past(acc_in)));

endmodule

// File: tb/wdp_accum_unit_tb.sv
module wdp_accum_unit_tb;
    localparam int LANES = 4;
    localparam int ACT_W = LANES * 32;
    localparam int MAX_W = 256;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic [1:0]       mode;
    logic             sat_en;
    logic [ACT_W-1:0] acc_in;
    logic [ACT_W-1:0] a_in;
    logic [ACT_W-1:0] b_in;
    logic             out_valid;
    logic [MAX_W-1:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    wdp_accum_unit #(.LANES(LANES)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .sat_en(sat_en),
        .acc_in(acc_in), .a_in(a_in), .b_in(b_in),
        .out_valid(out_valid), .result(result)
    );

    logic [15:0] wc [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    logic [31:0] ac [6] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
                            32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};

    function automatic logic [31:0] ref_lane(int m, bit s, logic [31:0] acc,
        logic [15:0] a0, logic [15:0] a1, logic [15:0] b0, logic [15:0] b1);
        longint ea0, ea1, eb0, eb1, ex, sum;
        bit asg = (m == 0);
        bit bsg = (m == 1);
        bit rsg = (m < 2);
        ea0 = asg ? longint'($signed(a0)) : longint'(a0);
        ea1 = asg ? longint'($signed(a1)) : longint'(a1);
        eb0 = bsg ? longint'($signed(b0)) : longint'(b0);
        eb1 = bsg ? longint'($signed(b1)) : longint'(b1);
        ex  = rsg ? longint'($signed(acc)) : longint'(acc);
        sum = ex + ea0 * eb0 + ea1 * eb1;
        if (s) begin
            if (rsg) begin
                if (sum > 64'sd2147483647)  return 32'h7FFF_FFFF;
                if (sum < -64'sd2147483648) return 32'h8000_0000;
            end else begin
                if (sum > 64'sd4294967295)  return 32'hFFFF_FFFF;
                if (sum < 0)                return 32'h0;
            end
        end
        return sum[31:0];
    endfunction

    function automatic logic [MAX_W-1:0] ref_vec(int m, bit s, logic [ACT_W-1:0] acc,
        logic [ACT_W-1:0] a, logic [ACT_W-1:0] b);
        logic [MAX_W-1:0] v = '0;
        for (int j = 0; j < LANES; j++)
            v[32*j +: 32] = ref_lane(m, s, acc[32*j +: 32], a[32*j +: 16],
                                     a[32*j+16 +: 16], b[32*j +: 16], b[32*j+16 +: 16]);
        return v;
    endfunction

    task automatic chk(string tag, logic [MAX_W-1:0] act, logic [MAX_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(int m, bit s, logic [ACT_W-1:0] acc,
        logic [ACT_W-1:0] a, logic [ACT_W-1:0] b, string tag);
        logic [MAX_W-1:0] exp;
        @(negedge clk);
        mode = 2'(m); sat_en = s; acc_in = acc; a_in = a; b_in = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        exp = ref_vec(m, s, acc, a, b);
        chk(tag, result, exp);
        chk("R9 valid", {255'b0, out_valid}, 256'd1);
        chk("R8 upper", result >> ACT_W, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [MAX_W-1:0] held;
        logic [ACT_W-1:0] va, vb, vc;
        rst = 1'b1; in_valid = 1'b0; mode = 2'b00; sat_en = 1'b0;
        acc_in = '0; a_in = '0; b_in = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 result", result, '0);
        chk("R10 valid", {255'b0, out_valid}, '0);
        rst = 1'b0;

        // R1: distinct per-lane operands, unsigned wrap
        for (int j = 0; j < LANES; j++) begin
            vc[32*j +: 32] = 32'(1000 * (j + 1));
            va[32*j +: 32] = {16'(j + 2), 16'(j + 1)};
            vb[32*j +: 32] = {16'(5 + j), 16'(3)};
        end
        run_vec(2, 0, vc, va, vb, "R1 lanes");

        // R9: hold while idle, with inputs changed
        held = result;
        @(negedge clk);
        acc_in = ~acc_in; a_in = ~a_in; b_in = 32'h5555 * b_in;
        @(negedge clk);
        chk("R9 hold", result, held);
        chk("R9 idle", {255'b0, out_valid}, '0);

        // R11: large positive and negative products cancel, exact result
        va = {LANES{16'h8000, 16'h7FFF}};
        vb = {LANES{16'hFFFF, 16'hFFFF}};
        vc = {LANES{32'h7FFF_FFFF}};
        run_vec(0, 1, vc, va, vb, "R11 exact");
        chk("R11 value", result[31:0], 256'(32'h7FFF_FFFF - 32'd65535));

        // sweep of corner operands across every mode code and both sum policies
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 2; s++)
                for (int ia = 0; ia < 6; ia++)
                    for (int ib = 0; ib < 6; ib++)
                        for (int ic = 0; ic < 6; ic++) begin
                            string mt, st;
                            mt = (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
                            st = (s == 0) ? "R5" : (m >= 2) ? "R7" : "R6";
                            for (int j = 0; j < LANES; j++) begin
                                va[32*j +: 32] = {wc[(ib + 2*j + 1) % 6], wc[(ia + j) % 6]};
                                vb[32*j +: 32] = {wc[(ia + j + 2) % 6], wc[(ib + j) % 6]};
                                vc[32*j +: 32] = ac[(ic + j) % 6];
                            end
                            run_vec(m, s[0], vc, va, vb, {mt, "/", st});
                        end

        // R10: reset in mid-run
        run_vec(1, 1, {LANES{32'h7FFF_FFFF}}, {LANES{32'h7FFF_7FFF}},
                {LANES{32'h7FFF_7FFF}}, "R6 pre-reset");
        rst = 1'b1;
        @(negedge clk);
        chk("R10 mid result", result, '0);
        chk("R10 mid valid", {255'b0, out_valid}, '0);
        rst = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule